// File: doc/BRIEF.md
# AUX Reply Outcome Classifier

This block decides what happened on one auxiliary-channel attempt once the channel hardware has stopped. The control logic starts it with a one-cycle `start` pulse. It then watches the channel's done flag, the receiver error flags, the hot-plug-lost flag and the reply byte count, and settles on a single channel result. If the channel result is a success, it reads the first received byte from the receive buffer and decodes the reply code from that byte's high nibble.

For an acknowledged reply, the block checks the data length against the size of the destination. If the data fits, it copies the data bytes one per cycle into an output buffer. It ends every attempt with a one-cycle result strobe. The result fields then stay unchanged until the next attempt starts, so a sequencer that handles retries and deferrals can read them at any later time.

Top module: `aux_outcome_unit`

## Requirements
- R1: After reset, `res_valid` and `obuf_we` are 0, `chan_res` is 0, `reply_code` is 5 (invalid) and `data_bytes` is 0.
- R2: When hot-plug-lost is high at the moment of classification, `chan_res` is 3 (disconnect). This holds even if timeout or framing flags are set, and even if done never came. `reply_code` is then 5 and `data_bytes` is 0.
- R3: When done is seen and either receive-timeout flag is set (`rx_flags` bit 0 or bit 1), `chan_res` is 1 (timeout).
- R4: When neither timeout flag is set but any framing flag is set (`rx_flags` bits 2 to 5: bad stop, nothing detected, bad high, bad low), `chan_res` is 2 (invalid reply).
- R5: With no flag set, a reply count of 0 gives `chan_res` 2.
- R6: If done does not arrive, `chan_res` becomes 1. `res_valid` rises on the TMO_CYC-th rising edge after the edge that accepts `start`. A done seen on that same edge is still classified normally.
- R7: `rx_flags` bit 6 (the minimum-count debug flag) has no effect on any output.
- R8: On a channel success, `chan_res` is 0 and `data_bytes` is count minus 1. `reply_code` is decoded from bits 7:4 of receive byte 0 as follows: 0 gives 0 (ACK), 1 gives 1 (NACK), 2 gives 2 (DEFER), 4 gives 3 (I2C NACK) and 8 gives 4 (I2C DEFER). Any other nibble gives 5.
- R9: For an ACK that fits, receive byte i+1 is written to output address i, for i from 0 to `data_bytes`-1. The writes go in ascending order, one per cycle, and all finish before `res_valid`. No write happens for any other outcome.
- R10: An ACK whose data count exceeds `dest_size` is rejected. `reply_code` is 5, `data_bytes` is 0, `chan_res` stays 0 and nothing is written.
- R11: `res_valid` is high for exactly one cycle per attempt. When `chan_res` is not 0, `reply_code` is 5 and `data_bytes` is 0. All result outputs hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins classification of an attempt |
| done | input | 1 | Channel finished flag |
| hpd_lost | input | 1 | Hot-plug signal dropped |
| rx_flags | input | 7 | Receiver flags: 0,1 timeout; 2..5 framing; 6 debug |
| reply_cnt | input | CNT_W | Bytes received, including the status byte |
| dest_size | input | CNT_W | Capacity of the destination buffer in bytes |
| rbuf_addr | output | CNT_W | Receive buffer read index |
| rbuf_data | input | 8 | Receive buffer byte at `rbuf_addr` (same cycle) |
| obuf_we | output | 1 | Output buffer write enable |
| obuf_addr | output | CNT_W | Output buffer write index |
| obuf_data | output | 8 | Output buffer write byte |
| res_valid | output | 1 | One-cycle result strobe |
| chan_res | output | 2 | 0 success, 1 timeout, 2 invalid, 3 disconnect |
| reply_code | output | 3 | 0 ACK, 1 NACK, 2 DEFER, 3 I2C NACK, 4 I2C DEFER, 5 invalid |
| data_bytes | output | CNT_W | Number of data bytes in the reply |

## Verification
A wrong internal state shows up at the ports as a wrong field on the cycle of the result strobe. Examples are a priority slip, where a framing result wins over disconnect, and a decode slip, where a nibble maps to the wrong code. An off-by-one in the copy index shows up one cycle after the copy starts, as a write to an out-of-order or out-of-range address. A timer that counts wrong moves the strobe away from its fixed edge after `start`. A state that does not return to rest shows up as a missing strobe, or as result fields that change without a new `start`.

// File: rtl/aux_oc_pkg.sv
package aux_oc_pkg;
  typedef enum logic [1:0] {
    CH_OK  = 2'd0,
    CH_TMO = 2'd1,
    CH_BAD = 2'd2,
    CH_HPD = 2'd3
  } chan_e;

  typedef enum logic [2:0] {
    RC_ACK       = 3'd0,
    RC_NACK      = 3'd1,
    RC_DEFER     = 3'd2,
    RC_I2C_NACK  = 3'd3,
    RC_I2C_DEFER = 3'd4,
    RC_INV       = 3'd5
  } code_e;

  localparam int FLAG_W = 7;
  localparam logic [FLAG_W-1:0] TMO_MASK   = 7'b0000011;
  localparam logic [FLAG_W-1:0] FRAME_MASK = 7'b0111100;

  function automatic code_e map_code(input logic [3:0] nib);
    case (nib)
      4'd0:    return RC_ACK;
      4'd1:    return RC_NACK;
      4'd2:    return RC_DEFER;
      4'd4:    return RC_I2C_NACK;
      4'd8:    return RC_I2C_DEFER;
      default: return RC_INV;
    endcase
  endfunction

  function automatic logic any_tmo(input logic [FLAG_W-1:0] f);
    return |(f & TMO_MASK);
  endfunction

  function automatic logic any_frame(input logic [FLAG_W-1:0] f);
    return |(f & FRAME_MASK);
  endfunction
endpackage

// File: rtl/aux_oc_timer.sv
module aux_oc_timer #(
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TMO_CYC) + 1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == TW'(TMO_CYC - 1));
endmodule

// File: rtl/aux_oc_chan_sort.sv
module aux_oc_chan_sort
  import aux_oc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              waiting,
  input  logic              done,
  input  logic              expired,
  input  logic              hpd_lost,
  input  logic [FLAG_W-1:0] flags,
  input  logic [CNT_W-1:0]  cnt,
  output logic              fire,
  output chan_e             verdict
);
  assign fire = waiting && (done || expired);

  always_comb begin
    if (hpd_lost)            verdict = CH_HPD;
    else if (!done)          verdict = CH_TMO;
    else if (any_tmo(flags)) verdict = CH_TMO;
    else if (any_frame(flags)) verdict = CH_BAD;
    else if (cnt == '0)      verdict = CH_BAD;
    else                     verdict = CH_OK;
  end
endmodule

// File: rtl/aux_oc_head.sv
module aux_oc_head
  import aux_oc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       head_nib,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [CNT_W-1:0] dest_size,
  output code_e            code,
  output logic             reject,
  output logic             need_copy
);
  assign code      = map_code(head_nib);
  assign reject    = (code == RC_ACK) && (nbytes > dest_size);
  assign need_copy = (code == RC_ACK) && !reject && (nbytes != '0);
endmodule

// File: rtl/aux_outcome_unit.sv
module aux_outcome_unit
  import aux_oc_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  input  logic             hpd_lost,
  input  logic [6:0]       rx_flags,
  input  logic [CNT_W-1:0] reply_cnt,
  input  logic [CNT_W-1:0] dest_size,
  output logic [CNT_W-1:0] rbuf_addr,
  input  logic [7:0]       rbuf_data,
  output logic             obuf_we,
  output logic [CNT_W-1:0] obuf_addr,
  output logic [7:0]       obuf_data,
  output logic             res_valid,
  output logic [1:0]       chan_res,
  output logic [2:0]       reply_code,
  output logic [CNT_W-1:0] data_bytes
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HEAD, S_COPY} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] nb_q, idx_q;
  chan_e            chan_q;
  code_e            code_q;
  logic [CNT_W-1:0] nbytes_q;
  logic             valid_q;

  // named internal events for the checker
  logic  at_rest, take_start, eval_fire, expired;
  chan_e verdict;
  code_e head_code;
  logic  head_reject, head_copy, copy_last;

  assign at_rest    = (st_q == S_IDLE);
  assign take_start = at_rest && start;
  assign copy_last  = (st_q == S_COPY) && (idx_q == nb_q);

  aux_oc_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(take_start),
    .run(st_q == S_WAIT), .expired(expired)
  );

  aux_oc_chan_sort #(.CNT_W(CNT_W)) u_sort (
    .waiting(st_q == S_WAIT), .done(done), .expired(expired),
    .hpd_lost(hpd_lost), .flags(rx_flags), .cnt(reply_cnt),
    .fire(eval_fire), .verdict(verdict)
  );

  aux_oc_head #(.CNT_W(CNT_W)) u_head (
    .head_nib(rbuf_data[7:4]), .nbytes(nb_q), .dest_size(dest_size),
    .code(head_code), .reject(head_reject), .need_copy(head_copy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      nb_q     <= '0;
      idx_q    <= '0;
      chan_q   <= CH_OK;
      code_q   <= RC_INV;
      nbytes_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          st_q     <= S_WAIT;
          chan_q   <= CH_OK;
          code_q   <= RC_INV;
          nbytes_q <= '0;
        end
        S_WAIT: if (eval_fire) begin
          chan_q <= verdict;
          if (verdict != CH_OK) begin
            valid_q <= 1'b1;
            st_q    <= S_IDLE;
          end else begin
            nb_q <= CNT_W'(reply_cnt - 1'b1);
            st_q <= S_HEAD;
          end
        end
        S_HEAD: begin
          if (head_reject) begin
            code_q   <= RC_INV;
            nbytes_q <= '0;
          end else begin
            code_q   <= head_code;
            nbytes_q <= nb_q;
          end
          if (head_copy) begin
            idx_q <= CNT_W'(1);
            st_q  <= S_COPY;
          end else begin
            valid_q <= 1'b1;
            st_q    <= S_IDLE;
          end
        end
        S_COPY: begin
          if (copy_last) begin
            valid_q <= 1'b1;
            st_q    <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rbuf_addr  = (st_q == S_COPY) ? idx_q : '0;
  assign obuf_we    = (st_q == S_COPY);
  assign obuf_addr  = CNT_W'(idx_q - 1'b1);
  assign obuf_data  = rbuf_data;
  assign res_valid  = valid_q;
  assign chan_res   = chan_q;
  assign reply_code = code_q;
  assign data_bytes = nbytes_q;
endmodule

// File: rtl/aux_oc_check.sv
module aux_oc_check #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             hpd_lost,
  input logic             eval_fire,
  input logic             at_rest,
  input logic             res_valid,
  input logic [1:0]       chan_res,
  input logic [2:0]       reply_code,
  input logic [CNT_W-1:0] data_bytes,
  input logic             obuf_we,
  input logic [CNT_W-1:0] obuf_addr,
  input logic [CNT_W-1:0] dest_size
);
  assert_hpd_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire && hpd_lost |=> res_valid && chan_res == 2'd3);

  assert_no_done_tmo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire && !hpd_lost && !done |=> res_valid && chan_res == 2'd1);

  assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    obuf_we |-> obuf_addr < dest_size);

  assert_write_before_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !obuf_we);

  assert_one_shot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_fail_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && chan_res != 2'd0 |-> reply_code == 3'd5 && data_bytes == '0);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    at_rest && !start |=> $stable(chan_res) && $stable(reply_code) && $stable(data_bytes));
endmodule

bind aux_outcome_unit aux_oc_check #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .hpd_lost(hpd_lost),
  .eval_fire(eval_fire), .at_rest(at_rest), .res_valid(res_valid),
  .chan_res(chan_res), .reply_code(reply_code), .data_bytes(data_bytes),
  .obuf_we(obuf_we), .obuf_addr(obuf_addr), .dest_size(dest_size)
);

// File: tb/aux_outcome_unit_bench.sv
module aux_outcome_unit_bench;
  localparam int CW  = 5;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, done = 1'b0, hpd_lost = 1'b0;
  logic [6:0] rx_flags = '0;
  logic [CW-1:0] reply_cnt = '0, dest_size = '0;
  logic [CW-1:0] rbuf_addr, obuf_addr, data_bytes;
  logic [7:0] rbuf_data, obuf_data;
  logic obuf_we, res_valid;
  logic [1:0] chan_res;
  logic [2:0] reply_code;

  logic [7:0] mem [32];
  logic [7:0] got [32];
  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign rbuf_data = mem[rbuf_addr];

  aux_outcome_unit #(.CNT_W(CW), .TMO_CYC(TMO)) u_aux_outcome_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .hpd_lost(hpd_lost),
    .rx_flags(rx_flags), .reply_cnt(reply_cnt), .dest_size(dest_size),
    .rbuf_addr(rbuf_addr), .rbuf_data(rbuf_data), .obuf_we(obuf_we),
    .obuf_addr(obuf_addr), .obuf_data(obuf_data), .res_valid(res_valid),
    .chan_res(chan_res), .reply_code(reply_code), .data_bytes(data_bytes)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nib_code(input logic [3:0] n);
    if (n == 4'h0) return 0;
    if (n == 4'h1) return 1;
    if (n == 4'h2) return 2;
    if (n == 4'h4) return 3;
    if (n == 4'h8) return 4;
    return 5;
  endfunction

  task automatic attempt(input bit h, input logic [6:0] f, input int c, input int ds,
                         input bit gd, input int k);
    int ech, ecode, enb, ewr, lat, nwr;
    bit order_ok;
    ech = 0; ecode = 5; enb = 0; ewr = 0;
    if (h) ech = 3;
    else if (!gd) ech = 1;
    else if (f[0] || f[1]) ech = 1;
    else if (f[2] || f[3] || f[4] || f[5]) ech = 2;
    else if (c == 0) ech = 2;
    else begin
      ecode = nib_code(mem[0][7:4]);
      enb = c - 1;
      if (ecode == 0 && enb > ds) begin ecode = 5; enb = 0; end
      else if (ecode == 0) ewr = enb;
    end
    hpd_lost = h; rx_flags = f; reply_cnt = CW'(c); dest_size = CW'(ds);
    done = 1'b0; nwr = 0; order_ok = 1; lat = -1;
    @(negedge clk);
    start = 1'b1;
    if (gd && k == 0) done = 1'b1;
    for (int i = 1; i < TMO + 50; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (obuf_we) begin
        if (obuf_addr != CW'(nwr)) order_ok = 0;
        got[obuf_addr] = obuf_data;
        nwr++;
      end
      if (res_valid) begin lat = i; break; end
      if (gd && i == k) done = 1'b1;
    end
    done = 1'b0;
    chk(lat > 0, "R11 strobe seen", lat, 1);
    chk(chan_res == 2'(ech), (ech == 3) ? "R2 chan" : (ech == 1) ? "R3/R6 chan" :
        (ech == 2) ? "R4/R5 chan" : "R8 chan", chan_res, ech);
    chk(reply_code == 3'(ecode), (ech != 0) ? "R11 code" : "R8/R10 code", reply_code, ecode);
    chk(data_bytes == CW'(enb), "R8/R10 data_bytes", data_bytes, enb);
    chk(nwr == ewr && order_ok, "R9 write count/order", nwr, ewr);
    for (int j = 0; j < ewr; j++)
      chk(got[j] == mem[j+1], "R9 copied byte", got[j], mem[j+1]);
    if (!gd) chk(lat == TMO + 1, "R6 timeout latency", lat, TMO + 1);
    @(negedge clk);
    chk(!res_valid, "R11 one cycle strobe", res_valid, 0);
    repeat (3) @(negedge clk);
    chk(chan_res == 2'(ech) && reply_code == 3'(ecode) && data_bytes == CW'(enb),
        "R11 hold", reply_code, ecode);
  endtask

  task automatic fill(input logic [3:0] nib);
    for (int j = 0; j < 32; j++) mem[j] = 8'($urandom);
    mem[0][7:4] = nib;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_up();
      end
    end
  end

  initial begin
    logic [3:0] nibs [8];
    void'($urandom(32'd4711));
    for (int j = 0; j < 32; j++) begin mem[j] = 8'h0; got[j] = 8'h0; end
    repeat (3) @(negedge clk);
    chk(!res_valid && !obuf_we, "R1 strobes", res_valid, 0);
    chk(chan_res == 0 && reply_code == 5 && data_bytes == 0, "R1 fields", reply_code, 5);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: disconnect beats other flags, with and without done
    fill(4'h0); attempt(1, 7'h3F, 5, 8, 1, 2);
    fill(4'h0); attempt(1, 7'h00, 5, 8, 0, 0);
    // R3: each timeout flag; R4: each framing flag
    fill(4'h0); attempt(0, 7'h01, 5, 8, 1, 1);
    fill(4'h0); attempt(0, 7'h02, 5, 8, 1, 3);
    for (int b = 2; b < 6; b++) begin fill(4'h0); attempt(0, 7'(1 << b), 5, 8, 1, 1); end
    // R5: zero count
    fill(4'h0); attempt(0, 7'h00, 0, 8, 1, 1);
    // R6: no done, and done on the last allowed edge
    fill(4'h0); attempt(0, 7'h00, 4, 8, 0, 0);
    fill(4'h0); attempt(0, 7'h00, 4, 8, 1, TMO);
    // R7: debug flag alone leaves an ACK copy untouched
    fill(4'h0); attempt(0, 7'h40, 6, 8, 1, 1);
    // R8: every code nibble
    for (int n = 0; n < 16; n++) begin fill(4'(n)); attempt(0, 7'h00, 3, 8, 1, 0); end
    // R10: one over capacity rejected, exact capacity accepted, single status byte
    fill(4'h0); attempt(0, 7'h00, 9, 7, 1, 1);
    fill(4'h0); attempt(0, 7'h00, 8, 7, 1, 1);
    fill(4'h0); attempt(0, 7'h00, 1, 0, 1, 1);
    fill(4'h0); attempt(0, 7'h00, 31, 31, 1, 1);

    nibs = '{4'h0, 4'h0, 4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'hF};
    for (int t = 0; t < 300; t++) begin
      logic [6:0] f;
      bit h, gd;
      int c, ds, k;
      f = ($urandom % 4 == 0) ? 7'($urandom) : (($urandom % 3 == 0) ? 7'h40 : 7'h00);
      h = ($urandom % 12 == 0);
      gd = ($urandom % 10 != 0);
      c = $urandom % 20;
      ds = $urandom % 20;
      k = $urandom % TMO;
      fill(nibs[$urandom % 8]);
      attempt(h, f, c, ds, gd, k);
    end
    finish_up();
  end
endmodule